// File: doc/BRIEF.md
# Macroinstruction Register with Decode RAM

This block keeps a 32-bit instruction word that carries two packed 16-bit macroinstructions, the high one in bits 31:16 and the low one in bits 15:0. One bit of an external location counter picks which half is current, and a flip control can invert that choice. The selected half can be read back at all times. Software-visible loads overwrite the whole word in one cycle.

A 10-bit opcode field, bits 15:6 of the selected half, indexes a decode RAM of 16-bit entries. Two optional upper address bits come from a mode field when its enable bit is set, so all 4096 entries are reachable; with the enable clear, only the lowest quarter is used. A dispatch strobe registers the addressed entry onto the dispatch output, where the microsequencer takes it as its next micro-address.

Decode RAM writes are slow: the address is taken from the register contents and mode field in the cycle the write strobe is seen, and the entry changes at the following clock edge. A dispatch issued in that following cycle, on the same entry, already sees the new value.

Top module: `macro_instr_decode`

## Requirements
- R1: During and after reset, `dispValid` is 0, `dispAddr` is 0 and the register word is 0, so `irHalf` reads 0.
- R2: A cycle with `irLoadEn` high stores `irLoadData` as the new word, visible on `irHalf` from the next cycle.
- R3: When `lcBit XOR halfFlip` is 1, `irHalf` is word bits 15:0. When it is 0, `irHalf` is bits 31:16.
- R4: With `extEnable` low, the entry index is zero in bits 11:10 and bits 15:6 of `irHalf` in bits 9:0. `extHigh` has no effect.
- R5: With `extEnable` high, `extHigh` supplies index bits 11:10.
- R6: `ramWrEn` captures `ramWrData` and the current entry index in that cycle. The entry changes at the next edge. A register load in that next cycle does not redirect the write.
- R7: A cycle with `dispatchEn` high puts the indexed entry on `dispAddr` from the next cycle, with `dispValid` high for exactly that one cycle. Without a dispatch, `dispAddr` holds its value.
- R8: A dispatch in the cycle right after a write to the same entry returns the newly written data.
- R9: Every one of the 4096 entries stores its value independently of all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irLoadEn | input | 1 | Load the instruction word |
| irLoadData | input | 32 | Word to load, two 16-bit halves |
| lcBit | input | 1 | Location counter bit 1; 1 selects the low half |
| halfFlip | input | 1 | Inverts the half choice |
| extEnable | input | 1 | Enables the upper index extension |
| extHigh | input | 2 | Upper index bits 11:10 |
| ramWrEn | input | 1 | Decode RAM write strobe (slow) |
| ramWrData | input | 16 | Entry data to write |
| dispatchEn | input | 1 | Dispatch strobe |
| irHalf | output | 16 | Selected half, readback |
| dispAddr | output | 16 | Registered decode RAM entry |
| dispValid | output | 1 | High the cycle after a dispatch |

## Verification
The assertions assume that the strobes and data inputs are known values at each rising edge. They also assume that the load data and write data are not X when their strobes are high. The bypass property compares the entry index across the write and dispatch cycles, so it relies on no other input forcing the index between them.

The stimulus drives every input shortly after a rising edge and holds it for a full cycle. It writes all 4096 entries before it dispatches any of them, so no dispatch ever reads an unwritten location.

// File: rtl/mid_pkg.sv
package mid_pkg;
  localparam int HALF_W  = 16;
  localparam int OPC_LSB = 6;
  localparam int OPC_W   = 10;
  localparam int EXT_W   = 2;
  localparam int ENTRY_W = 16;

  typedef struct packed {
    logic loadIr;
    logic capWr;
    logic commitWr;
    logic dispatch;
  } strobe_t;
endpackage

// File: rtl/mid_ctrl.sv
module mid_ctrl (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irLoadEn,
  input  logic             ramWrEn,
  input  logic             dispatchEn,
  output mid_pkg::strobe_t strobes
);
  logic pendValid;

  always_ff @(posedge clk) begin
    if (!rstN) pendValid <= 1'b0;
    else       pendValid <= ramWrEn;
  end

  always_comb begin
    strobes.loadIr   = irLoadEn;
    strobes.capWr    = ramWrEn;
    strobes.commitWr = pendValid;
    strobes.dispatch = dispatchEn;
  end
endmodule

// File: rtl/mid_datapath.sv
module mid_datapath #(
  parameter int HALF_W  = mid_pkg::HALF_W,
  parameter int OPC_LSB = mid_pkg::OPC_LSB,
  parameter int OPC_W   = mid_pkg::OPC_W,
  parameter int EXT_W   = mid_pkg::EXT_W,
  parameter int ENTRY_W = mid_pkg::ENTRY_W,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ADDR_W = OPC_W + EXT_W,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int EXT_PW = (EXT_W > 0) ? EXT_W : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  mid_pkg::strobe_t    strobes,
  input  logic [WORD_W-1:0]   irLoadData,
  input  logic                lcBit,
  input  logic                halfFlip,
  input  logic                extEnable,
  input  logic [EXT_PW-1:0]   extHigh,
  input  logic [ENTRY_W-1:0]  ramWrData,
  output logic [HALF_W-1:0]   irHalf,
  output logic [ADDR_W-1:0]   curAddr,
  output logic [ENTRY_W-1:0]  dispAddr,
  output logic                dispValid
);
  logic [WORD_W-1:0]  irWord;
  logic               lowSel;
  logic [OPC_W-1:0]   opcField;
  logic [ADDR_W-1:0]  pendAddr;
  logic [ENTRY_W-1:0] pendData;
  logic [ENTRY_W-1:0] readData;
  logic [ENTRY_W-1:0] decodeMem [DEPTH];

  // instruction word
  always_ff @(posedge clk) begin
    if (!rstN)               irWord <= '0;
    else if (strobes.loadIr) irWord <= irLoadData;
  end

  // half selection: counter bit set means the low half is executing
  assign lowSel   = lcBit ^ halfFlip;
  assign irHalf   = lowSel ? irWord[HALF_W-1:0] : irWord[WORD_W-1:HALF_W];
  assign opcField = irHalf[OPC_LSB +: OPC_W];

  // entry index, with or without an upper extension
  generate
    if (EXT_W > 0) begin : g_ext
      logic [EXT_PW-1:0] extBits;
      assign extBits = extEnable ? extHigh : '0;
      assign curAddr = {extBits, opcField};
    end else begin : g_noext
      logic unusedExt;
      assign unusedExt = extEnable ^ (^extHigh);
      assign curAddr   = opcField;
    end
  endgenerate

  // slow write: capture this cycle, commit next edge
  always_ff @(posedge clk) begin
    if (strobes.capWr) begin
      pendAddr <= curAddr;
      pendData <= ramWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.commitWr) decodeMem[pendAddr] <= pendData;
  end

  // forward a write being committed on this same edge
  always_comb begin
    if (strobes.commitWr && (pendAddr == curAddr)) readData = pendData;
    else                                           readData = decodeMem[curAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispAddr  <= '0;
      dispValid <= 1'b0;
    end else begin
      dispValid <= strobes.dispatch;
      if (strobes.dispatch) dispAddr <= readData;
    end
  end
endmodule

// File: rtl/macro_instr_decode.sv
module macro_instr_decode #(
  parameter int HALF_W  = mid_pkg::HALF_W,
  parameter int OPC_LSB = mid_pkg::OPC_LSB,
  parameter int OPC_W   = mid_pkg::OPC_W,
  parameter int EXT_W   = mid_pkg::EXT_W,
  parameter int ENTRY_W = mid_pkg::ENTRY_W,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ADDR_W = OPC_W + EXT_W,
  localparam int EXT_PW = (EXT_W > 0) ? EXT_W : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               irLoadEn,
  input  logic [WORD_W-1:0]  irLoadData,
  input  logic               lcBit,
  input  logic               halfFlip,
  input  logic               extEnable,
  input  logic [EXT_PW-1:0]  extHigh,
  input  logic               ramWrEn,
  input  logic [ENTRY_W-1:0] ramWrData,
  input  logic               dispatchEn,
  output logic [HALF_W-1:0]  irHalf,
  output logic [ENTRY_W-1:0] dispAddr,
  output logic               dispValid
);
  mid_pkg::strobe_t  strobes;
  logic [ADDR_W-1:0] curAddr;

  mid_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .irLoadEn   (irLoadEn),
    .ramWrEn    (ramWrEn),
    .dispatchEn (dispatchEn),
    .strobes    (strobes)
  );

  mid_datapath #(
    .HALF_W  (HALF_W),
    .OPC_LSB (OPC_LSB),
    .OPC_W   (OPC_W),
    .EXT_W   (EXT_W),
    .ENTRY_W (ENTRY_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .irLoadData (irLoadData),
    .lcBit      (lcBit),
    .halfFlip   (halfFlip),
    .extEnable  (extEnable),
    .extHigh    (extHigh),
    .ramWrData  (ramWrData),
    .irHalf     (irHalf),
    .curAddr    (curAddr),
    .dispAddr   (dispAddr),
    .dispValid  (dispValid)
  );
endmodule

// File: rtl/mid_checker.sv
module mid_checker #(
  parameter int HALF_W  = 16,
  parameter int ADDR_W  = 12,
  parameter int ENTRY_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               irLoadEn,
  input logic [2*HALF_W-1:0] irLoadData,
  input logic               lcBit,
  input logic               halfFlip,
  input logic               ramWrEn,
  input logic [ENTRY_W-1:0] ramWrData,
  input logic               dispatchEn,
  input logic [HALF_W-1:0]  irHalf,
  input logic [ADDR_W-1:0]  curAddr,
  input logic [ENTRY_W-1:0] dispAddr,
  input logic               dispValid
);
  // R2
  load_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    irLoadEn |=> (irHalf == ((lcBit ^ halfFlip) ? $past(irLoadData[HALF_W-1:0])
                                                : $past(irLoadData[2*HALF_W-1:HALF_W]))));
  // R7
  dispatch_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispatchEn |=> dispValid);
  // R7
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dispatchEn |=> !dispValid);
  // R7
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dispatchEn |=> $stable(dispAddr));
  // R8
  write_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramWrEn ##1 (dispatchEn && (curAddr == $past(curAddr))))
      |=> (dispAddr == $past(ramWrData, 2)));
endmodule

bind macro_instr_decode mid_checker #(
  .HALF_W (HALF_W),
  .ADDR_W (ADDR_W),
  .ENTRY_W(ENTRY_W)
) u_mid_checker (
  .clk        (clk),
  .rstN       (rstN),
  .irLoadEn   (irLoadEn),
  .irLoadData (irLoadData),
  .lcBit      (lcBit),
  .halfFlip   (halfFlip),
  .ramWrEn    (ramWrEn),
  .ramWrData  (ramWrData),
  .dispatchEn (dispatchEn),
  .irHalf     (irHalf),
  .curAddr    (curAddr),
  .dispAddr   (dispAddr),
  .dispValid  (dispValid)
);

// File: tb/test_macro_instr_decode.sv
`timescale 1ns/1ps
module test_macro_instr_decode;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irLoadEn = 1'b0;
  logic [31:0] irLoadData = '0;
  logic        lcBit = 1'b0;
  logic        halfFlip = 1'b0;
  logic        extEnable = 1'b0;
  logic [1:0]  extHigh = '0;
  logic        ramWrEn = 1'b0;
  logic [15:0] ramWrData = '0;
  logic        dispatchEn = 1'b0;
  logic [15:0] irHalf;
  logic [15:0] dispAddr;
  logic        dispValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  macro_instr_decode i_macro_instr_decode (
    .clk(clk), .rstN(rstN), .irLoadEn(irLoadEn), .irLoadData(irLoadData),
    .lcBit(lcBit), .halfFlip(halfFlip), .extEnable(extEnable), .extHigh(extHigh),
    .ramWrEn(ramWrEn), .ramWrData(ramWrData), .dispatchEn(dispatchEn),
    .irHalf(irHalf), .dispAddr(dispAddr), .dispValid(dispValid)
  );

  // behavioural reference model
  logic [15:0] refMem [int];
  logic [31:0] refWord = '0;
  logic [15:0] refDisp = '0;
  logic        refValid = 1'b0;
  bit          refPend = 0;
  int          refPendIdx = 0;
  logic [15:0] refPendData = '0;

  function automatic logic [15:0] pickHalf(logic [31:0] w, logic sel);
    return sel ? w[15:0] : w[31:16];
  endfunction

  function automatic int entryIdx(logic [31:0] w, logic sel, logic en, logic [1:0] hi);
    logic [15:0] h;
    h = pickHalf(w, sel);
    return (en ? int'(hi) * 1024 : 0) + int'(h[15:6]);
  endfunction

  function automatic logic [15:0] fillVal(int a);
    return 16'(a * 7) ^ 16'hA5C3;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      refWord = '0; refDisp = '0; refValid = 1'b0; refPend = 0;
    end else begin
      int idx;
      idx = entryIdx(refWord, lcBit ^ halfFlip, extEnable, extHigh);
      if (dispatchEn) begin
        if (refPend && refPendIdx == idx) refDisp = refPendData;
        else if (refMem.exists(idx))      refDisp = refMem[idx];
        else                              refDisp = 'x;
      end
      refValid = dispatchEn;
      if (refPend) refMem[refPendIdx] = refPendData;
      refPend = ramWrEn;
      if (ramWrEn) begin refPendIdx = idx; refPendData = ramWrData; end
      if (irLoadEn) refWord = irLoadData;
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(irHalf === pickHalf(refWord, lcBit ^ halfFlip), "R3 irHalf vs model", 32'(irHalf),
            32'(pickHalf(refWord, lcBit ^ halfFlip)));
      check(dispValid === refValid, "R7 dispValid vs model", 32'(dispValid), 32'(refValid));
      check(dispAddr === refDisp, "R7 dispAddr vs model", 32'(dispAddr), 32'(refDisp));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic loadWord(logic [31:0] w);
    irLoadEn = 1'b1; irLoadData = w; tick(); irLoadEn = 1'b0;
  endtask

  task automatic pointAt(int a);
    extEnable = 1'b1; extHigh = 2'(a >> 10);
    loadWord({6'(a), 10'(a), 6'h15, 10'(a), 6'h2A} & 32'hFFC0FFC0 | 32'h0015002A);
  endtask

  task automatic writeEntry(int a, logic [15:0] d);
    pointAt(a);
    ramWrEn = 1'b1; ramWrData = d; tick(); ramWrEn = 1'b0;
  endtask

  task automatic readEntry(int a, output logic [15:0] v);
    pointAt(a);
    dispatchEn = 1'b1; tick(); dispatchEn = 1'b0;
    v = dispAddr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) tick();
    // R1 reset state
    check(dispValid === 1'b0, "R1 dispValid in reset", 32'(dispValid), 0);
    check(dispAddr === 16'h0, "R1 dispAddr in reset", 32'(dispAddr), 0);
    check(irHalf === 16'h0, "R1 irHalf in reset", 32'(irHalf), 0);
    rstN = 1'b1; tick();
    check(dispValid === 1'b0 && irHalf === 16'h0, "R1 after reset", {dispValid, 15'd0, irHalf}, 0);

    // R2 / R3 load and half selection
    lcBit = 1'b1; loadWord(32'h1234ABCD);
    check(irHalf === 16'hABCD, "R2 readback low half", 32'(irHalf), 32'hABCD);
    lcBit = 1'b0; #1;
    check(irHalf === 16'h1234, "R3 high half when bit clear", 32'(irHalf), 32'h1234);
    halfFlip = 1'b1; #1;
    check(irHalf === 16'hABCD, "R3 flip inverts choice", 32'(irHalf), 32'hABCD);
    lcBit = 1'b1; #1;
    check(irHalf === 16'h1234, "R3 flip with bit set", 32'(irHalf), 32'h1234);
    halfFlip = 1'b0; lcBit = 1'b1;

    // R9 fill every entry, then read all back
    for (int a = 0; a < 4096; a++) writeEntry(a, fillVal(a));
    tick();
    for (int a = 0; a < 4096; a++) begin
      readEntry(a, v);
      check(v === fillVal(a), "R9 unique entry readback", 32'(v), 32'(fillVal(a)));
    end

    // R7 one-cycle valid and hold
    tick();
    check(dispValid === 1'b0, "R7 valid drops after one cycle", 32'(dispValid), 0);
    check(dispAddr === fillVal(4095), "R7 dispAddr holds", 32'(dispAddr), 32'(fillVal(4095)));

    // R4 extension disabled: extHigh ignored
    extEnable = 1'b0; extHigh = 2'b11;
    loadWord({16'h0, 10'd5, 6'h3F});
    dispatchEn = 1'b1; tick(); dispatchEn = 1'b0;
    check(dispAddr === fillVal(5), "R4 extHigh ignored when disabled", 32'(dispAddr), 32'(fillVal(5)));

    // R5 extension enabled
    extEnable = 1'b1; extHigh = 2'b10;
    dispatchEn = 1'b1; tick(); dispatchEn = 1'b0;
    check(dispAddr === fillVal(2053), "R5 extHigh supplies upper bits", 32'(dispAddr), 32'(fillVal(2053)));

    // R6 load during commit cycle does not redirect the write
    writeEntry(7, 16'hBEEF);
    pointAt(9);
    tick();
    readEntry(7, v);
    check(v === 16'hBEEF, "R6 write lands at captured index", 32'(v), 32'hBEEF);
    readEntry(9, v);
    check(v === fillVal(9), "R6 other entry untouched", 32'(v), 32'(fillVal(9)));

    // R8 write then dispatch next cycle on the same entry
    pointAt(12);
    ramWrEn = 1'b1; ramWrData = 16'h1357; tick();
    ramWrEn = 1'b0; dispatchEn = 1'b1; tick(); dispatchEn = 1'b0;
    check(dispAddr === 16'h1357, "R8 bypass of pending write", 32'(dispAddr), 32'h1357);
    check(dispValid === 1'b1, "R7 valid after dispatch", 32'(dispValid), 1);
    readEntry(12, v);
    check(v === 16'h1357, "R8 entry committed", 32'(v), 32'h1357);

    tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule